// File: doc/BRIEF.md
# Gated-Clock Eight-Stage Shift Register

This block is an eight-stage shift register. It can be filled in one step from an eight-bit parallel word, or one bit at a time from a serial input. Only the last stage can be seen from outside, on a single serial output.

All logic runs on one free-running system clock. Two external clock-control pins are treated as ordinary data inputs. Each pin passes through its own synchronizer, and the two synchronized pins are combined by OR into one effective shift clock. A rising edge of that combination moves the register one place. Either pin can therefore act as a second clock, or it can be held high to block shifting by the other pin.

A mode input selects between following the parallel word and shifting. An active-low clear empties the register at once, without waiting for a clock edge.

Top module: `shreg_clkinh`

## Requirements
- R1: While `clr_n` is low, every stage is 0 and `ser_out` is 0. This takes effect immediately, with no system-clock edge needed.
- R2: While `shift_ld` is 0, every system-clock edge copies `par_in[i]` into stage i. So `ser_out` shows `par_in[7]` just after that edge, and the register keeps following `par_in` on every cycle.
- R3: While `shift_ld` is 0, rising edges of the effective shift clock are discarded. The loaded value is not shifted, and no shift is held back to be applied later.
- R4: When `shift_ld` is 1, each shift moves `ser_in` into stage 0 and stage k into stage k+1. `ser_out` is stage 7, so after parallel word P and n shifts, `ser_out` equals P[7-n] for n from 0 to 7.
- R5: The effective shift clock is the OR of `clk_a` and `clk_b` after synchronization. A pin level that is present at system edge n causes the resulting shift at system edge n+2.
- R6: While one clock pin stays high, toggling the other pin causes no shift.
- R7: When `shift_ld` is 1 and there is no effective rising edge, all stages hold their value.
- R8: After `clr_n` is released, a clock pin that was already high causes no shift. The effective clock must first go low and then high again before a shift happens.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| shift_ld | input | 1 | 1 = shift mode, 0 = follow the parallel word |
| ser_in | input | 1 | Serial data entering stage 0 |
| par_in | input | 8 | Parallel word; bit i goes to stage i |
| clk_a | input | 1 | Clock-control pin A, sampled by the system clock |
| clk_b | input | 1 | Clock-control pin B, sampled by the system clock |
| ser_out | output | 1 | Content of the last stage |

## Verification
A parallel word with mixed bit values is loaded and then shifted out one place at a time. This shows the bit-to-stage mapping and the shift direction, and separates a correct shift from a reversed or stuck one.

Pulses on pin A alone and on pin B alone show that the two pins are combined by OR. Toggling one pin while the other is held high shows that a held pin blocks the other. Clock edges are also applied while loading, to show that loading wins and that no edge is kept back for later.

A pin is raised and the output is sampled on the cycle before and the cycle after the expected shift. This pins down the two-cycle synchronizer latency. Clear is asserted in the middle of a shift sequence and released with a pin held high, which separates the correct restart from a phantom shift.

Long random runs mix all inputs and are compared cycle by cycle against a reference model.

// File: rtl/shreg_pkg.sv
package shreg_pkg;

  localparam int DEF_DEPTH       = 8;
  localparam int DEF_SYNC_STAGES = 2;

  // register operation chosen each system cycle
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_SHIFT = 2'd2
  } shreg_op_e;

endpackage

// File: rtl/shreg_sync.sv
module shreg_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= RST_VAL;
        else        chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/shreg_edge.sv
module shreg_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_a,
  input  logic clk_b,
  output logic eff_clk,
  output logic shift_evt
);

  localparam int NPINS = 2;

  logic [NPINS-1:0] pin_raw;
  logic [NPINS-1:0] pin_s;
  logic             eff_prev;

  assign pin_raw = {clk_b, clk_a};

  // Synchronizers reset to 1 so a pin already high at clear release is not seen as a rising edge.
  generate
    for (genvar gi = 0; gi < NPINS; gi++) begin : g_pin
      shreg_sync #(
        .STAGES (SYNC_STAGES),
        .RST_VAL(1'b1)
      ) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pin_raw[gi]),
        .q    (pin_s[gi])
      );

      // R6: a synchronized pin held high for two cycles blocks any edge
      p_pin_inhibit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_s[gi] && $past(pin_s[gi])) |-> !shift_evt);
    end
  endgenerate

  assign eff_clk = |pin_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eff_prev <= 1'b1;
    else        eff_prev <= eff_clk;
  end

  assign shift_evt = eff_clk & ~eff_prev;

  // R5: an effective edge lasts a single system cycle
  p_evt_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt |=> !shift_evt);

  // R5: an edge needs the combined clock low on the cycle before
  p_evt_after_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt |-> !$past(eff_clk));

endmodule

// File: rtl/shreg_stages.sv
module shreg_stages
  import shreg_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sh_ld,
  input  logic             shift_evt,
  input  logic             ser_in,
  input  logic [DEPTH-1:0] par_in,
  output logic [DEPTH-1:0] stages
);

  function automatic logic [DEPTH-1:0] advance(input logic [DEPTH-1:0] cur,
                                               input logic din);
    return {cur[DEPTH-2:0], din};
  endfunction

  shreg_op_e op;
  logic      do_load;
  logic      do_shift;

  always_comb begin
    if (!sh_ld)         op = OP_LOAD;
    else if (shift_evt) op = OP_SHIFT;
    else                op = OP_HOLD;
  end

  assign do_load  = (op == OP_LOAD);
  assign do_shift = (op == OP_SHIFT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stages <= '0;
    else if (do_load)  stages <= par_in;
    else if (do_shift) stages <= advance(stages, ser_in);
  end

  // R1: clear keeps every stage at zero
  p_clear_zero_r1: assert property (@(posedge clk)
    !rst_n |-> (stages == '0));

  // R2 and R3: load mode copies the parallel word whatever the clock pins do
  p_load_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sh_ld |=> (stages == $past(par_in)));

  // R4: one shift per effective edge in shift mode
  p_shift_move_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_ld && shift_evt) |=> (stages == {$past(stages[DEPTH-2:0]), $past(ser_in)}));

  // R7: no edge, no change
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_ld && !shift_evt) |=> $stable(stages));

endmodule

// File: rtl/shreg_clkinh.sv
module shreg_clkinh
  import shreg_pkg::*;
#(
  parameter int DEPTH       = DEF_DEPTH,
  parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             shift_ld,
  input  logic             ser_in,
  input  logic [DEPTH-1:0] par_in,
  input  logic             clk_a,
  input  logic             clk_b,
  output logic             ser_out
);

  localparam int LAST = DEPTH - 1;

  logic             eff_clk;
  logic             shift_evt;
  logic [DEPTH-1:0] stages;

  shreg_edge #(
    .SYNC_STAGES(SYNC_STAGES)
  ) i_edge (
    .clk      (clk),
    .rst_n    (clr_n),
    .clk_a    (clk_a),
    .clk_b    (clk_b),
    .eff_clk  (eff_clk),
    .shift_evt(shift_evt)
  );

  shreg_stages #(
    .DEPTH(DEPTH)
  ) i_stages (
    .clk      (clk),
    .rst_n    (clr_n),
    .sh_ld    (shift_ld),
    .shift_evt(shift_evt),
    .ser_in   (ser_in),
    .par_in   (par_in),
    .stages   (stages)
  );

  assign ser_out = stages[LAST];

  // R8: no edge on the first cycle after clear
  p_no_edge_after_clear_r8: assert property (@(posedge clk) disable iff (!clr_n)
    $rose(clr_n) |-> !shift_evt);

  // R4: output follows the previous stage after a shift
  p_out_follow_r4: assert property (@(posedge clk) disable iff (!clr_n)
    (shift_ld && shift_evt) |=> (ser_out == $past(stages[LAST-1])));

  // R5: an effective edge implies at least one synchronized pin is high
  p_evt_needs_pin_r5: assert property (@(posedge clk) disable iff (!clr_n)
    shift_evt |-> eff_clk);

endmodule

// File: tb/test_shreg_clkinh.sv
`timescale 1ns/1ps
module test_shreg_clkinh;

  localparam int  W      = 8;
  localparam time TCLK   = 20ns;
  localparam int  MAXCYC = 200000;

  logic         clk = 1'b0;
  logic         clr_n;
  logic         shift_ld;
  logic         ser_in;
  logic [W-1:0] par_in;
  logic         clk_a;
  logic         clk_b;
  logic         ser_out;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 0;
  bit  rnd_on = 0;

  always #(TCLK/2) clk = ~clk;

  shreg_clkinh i_shreg_clkinh (
    .clk     (clk),
    .clr_n   (clr_n),
    .shift_ld(shift_ld),
    .ser_in  (ser_in),
    .par_in  (par_in),
    .clk_a   (clk_a),
    .clk_b   (clk_b),
    .ser_out (ser_out)
  );

  // reference model: pins seen two edges late, shift on rise of their OR
  logic [W-1:0] m_reg;
  logic         m_a1, m_a2, m_b1, m_b2, m_prev;

  function automatic logic m_edge(input logic a2, input logic b2, input logic prev);
    return (a2 | b2) && !prev;
  endfunction

  always @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      m_reg <= '0;
      m_a1 <= 1'b1; m_a2 <= 1'b1; m_b1 <= 1'b1; m_b2 <= 1'b1; m_prev <= 1'b1;
    end else begin
      m_a1   <= clk_a;  m_a2 <= m_a1;
      m_b1   <= clk_b;  m_b2 <= m_b1;
      m_prev <= m_a2 | m_b2;
      if (!shift_ld)                        m_reg <= par_in;
      else if (m_edge(m_a2, m_b2, m_prev))  m_reg <= {m_reg[W-2:0], ser_in};
    end
  end

  task automatic chk(input string req, input logic exp);
    n_chk++;
    if (ser_out !== exp) begin
      n_fail++;
      $display("FAIL %s: ser_out=%b expected %b at %0t", req, ser_out, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [W-1:0] p);
    shift_ld = 1'b0; par_in = p;
    cyc(1);
    shift_ld = 1'b1;
  endtask

  task automatic pulse_a();
    clk_a = 1'b1; cyc(3);
    clk_a = 1'b0; cyc(3);
  endtask

  task automatic pulse_b();
    clk_b = 1'b1; cyc(3);
    clk_b = 1'b0; cyc(3);
  endtask

  // random-phase comparison against the model
  always @(negedge clk) begin
    if (rnd_on && clr_n) chk("R4/R5/R7 random", m_reg[W-1]);
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (MAXCYC) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not end, actual running expected finished");
    finish_run();
  end

  initial begin
    logic [W-1:0] pat;
    void'($urandom(32'd4711));
    clr_n = 1'b0; shift_ld = 1'b1; ser_in = 1'b0; par_in = '0;
    clk_a = 1'b0; clk_b = 1'b0;
    cyc(2);
    chk("R1 reset", 1'b0);
    clr_n = 1'b1;
    cyc(3);

    // R2: load follows the parallel word every cycle
    shift_ld = 1'b0; par_in = 8'hA5;
    cyc(1); chk("R2 load A5", 1'b1);
    par_in = 8'h25;
    cyc(1); chk("R2 load follows", 1'b0);

    // R3: edges while loading are discarded
    par_in = 8'h80;
    cyc(1);
    clk_a = 1'b1; cyc(3); chk("R3 edge while loading", 1'b1);
    clk_a = 1'b0; cyc(3);
    clk_a = 1'b1; cyc(3); chk("R3 second edge", 1'b1);
    clk_a = 1'b0; cyc(3);

    // R7: shift mode without edges holds
    shift_ld = 1'b1; ser_in = 1'b0;
    cyc(5); chk("R7 hold", 1'b1);
    // R3: no shift left pending from edges during load
    cyc(3); chk("R3 nothing pending", 1'b1);

    // R4: load B2 then 8 shifts, ser_in=1
    pat = 8'hB2;
    load(pat);
    chk("R4 shift 0", pat[7]);
    ser_in = 1'b1;
    for (int k = 1; k <= 8; k++) begin
      pulse_a();
      if (k <= 7) chk($sformatf("R4 shift %0d", k), pat[7-k]);
      else        chk("R4 serial in reaches out", 1'b1);
    end

    // R5: pin B alone shifts, with two-cycle latency
    load(8'h40);
    ser_in = 1'b0;
    cyc(1);
    clk_b = 1'b1;
    cyc(2); chk("R5 before latency", 1'b0);
    cyc(1); chk("R5 after latency", 1'b1);
    clk_b = 1'b0; cyc(3);

    // R6: A held high blocks B
    load(8'h40);
    clk_a = 1'b1; cyc(3); chk("R6 A rise shifts", 1'b1);
    for (int t = 0; t < 4; t++) begin
      clk_b = 1'b1; cyc(3);
      clk_b = 1'b0; cyc(3);
    end
    chk("R6 inhibited", 1'b1);
    clk_a = 1'b0; cyc(3); chk("R6 falling no shift", 1'b1);
    pulse_b(); chk("R6 released", 1'b0);

    // R1/R8: clear mid-shift, released with A high
    load(8'hFF);
    pulse_a(); pulse_a();
    chk("R4 before clear", 1'b1);
    ser_in = 1'b1; clk_a = 1'b1;
    #5ns clr_n = 1'b0;
    #1ns chk("R1 async clear", 1'b0);
    cyc(2);
    clr_n = 1'b1;
    cyc(5);
    ser_in = 1'b0;
    for (int k = 0; k < 7; k++) begin
      clk_a = 1'b0; cyc(3);
      clk_a = 1'b1; cyc(3);
    end
    chk("R8 no phantom shift", 1'b0);
    clk_a = 1'b0; cyc(3);

    // random phase
    rnd_on = 1;
    for (int c = 0; c < 3000; c++) begin
      shift_ld = ($urandom_range(0, 9) != 0);
      ser_in   = $urandom_range(0, 1);
      par_in   = W'($urandom);
      if ($urandom_range(0, 3) == 0) clk_a = ~clk_a;
      if ($urandom_range(0, 5) == 0) clk_b = ~clk_b;
      cyc(1);
    end
    rnd_on = 0;
    finish_run();
  end

endmodule